// File: doc/BRIEF.md
# Interrupt Request and Service Tracker

This block keeps the per-vector interrupt state for one processor core: a 256-bit request set, a 256-bit in-service set and a 256-bit enable mask. Interrupt sources raise a vector by number. The block answers each raise in the same cycle with a status. The status tells the source whether the raise was refused, absorbed without any new work, or turned into a fresh request that the core must service.

Towards the core, the block presents a pending flag and the vector that should be taken next. A request is deliverable only when it outranks everything already in service, and a higher vector number means a higher rank. The core acknowledges a vector to move it from requested to in service. An end-of-interrupt strobe retires the highest vector in service. Enable bits are written one vector at a time.

Top module: `irq_track`

## Requirements
- R1: A raise whose vector is below 16 or above 255 gets status ERROR (2'b10) and changes no request, in-service or enable bit.
- R2: A raise of a vector whose request bit is already set gets status OK (2'b00) and leaves the state as it was.
- R3: A raise of a vector in 16..255 that is enabled and not requested gets status SERVICE (2'b01), and the request bit is set at the next rising edge.
- R4: A raise of a vector in 16..255 whose enable bit is clear gets status OK (2'b00) and is dropped: no bit changes.
- R5: With `en_we` high, the enable bit of `en_vec` takes the value of `en_val` at the next edge. A raise in the same cycle is judged against the enable bit as it was before that edge.
- R6: An acknowledge of a vector whose request bit is set clears that request bit and sets its in-service bit at the next edge. An acknowledge of a vector that is not requested has no effect.
- R7: `eoi` clears the in-service bit of the highest-numbered vector in service at the next edge. With nothing in service it has no effect.
- R8: `pend` is high when at least one request exists and the highest request is above the highest in-service vector, or nothing is in service. `pend_vec` then shows the highest requested vector. It shows 0 when `pend` is low.
- R9: A synchronous active-high `rst` clears all request, in-service and enable bits.
- R10: `raise_status` is combinational from the inputs and the current state. When several operations occur in one cycle, each is judged against the state before the edge. A raise and an acknowledge of the same requested vector in the same cycle leave it not requested and in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| raise_valid | input | 1 | A raise is presented this cycle |
| raise_vec | input | 9 | Raised vector number (0..511 so out-of-range values can be expressed) |
| raise_status | output | 2 | 00 OK, 01 SERVICE, 10 ERROR; meaningful while raise_valid is high |
| ack_valid | input | 1 | The core acknowledges a vector |
| ack_vec | input | 8 | Acknowledged vector |
| eoi | input | 1 | End-of-interrupt strobe |
| en_we | input | 1 | Enable-bit write strobe |
| en_vec | input | 8 | Vector whose enable bit is written |
| en_val | input | 1 | New enable bit value |
| pend | output | 1 | A deliverable interrupt is pending |
| pend_vec | output | 8 | Vector to deliver when pend is high, else 0 |

## Verification
Several properties are checked every cycle by assertions. No request bit below 16 is ever set. Refused and disabled raises leave the request set unchanged. A SERVICE answer is followed by the request bit being set. Acknowledges move a bit from request to in-service. Enable writes land on the addressed bit. EOI clears the bit that was highest in service. Any vector that is shown as pending is actually requested. The bench scenarios cover what needs a history of operations. These are coalescing after a prior raise, the rank comparison that holds back a lower request behind a higher one in service, nested EOIs retiring vectors in order, same-cycle raise, acknowledge and enable combinations, and a long mixed stream checked against an independent model.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

    typedef enum logic [1:0] {
        RS_OK      = 2'b00,
        RS_SERVICE = 2'b01,
        RS_ERROR   = 2'b10
    } raise_status_e;

    typedef struct packed {
        logic found;
        logic [7:0] idx;
    } hi_result_t;

endpackage

// File: rtl/irq_hi_find.sv
module irq_hi_find #(
    parameter int unsigned WIDTH = 256,
    parameter int unsigned IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scans upward; the last set bit seen is the highest one.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_bank.sv
module irq_vec_bank
    import irq_trk_pkg::*;
#(
    parameter int unsigned NUM_VEC  = 256,
    parameter int unsigned LOW_RSVD = 16,
    parameter int unsigned IDX_W    = $clog2(NUM_VEC),
    parameter int unsigned RAISE_W  = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               raise_valid,
    input  logic [RAISE_W-1:0] raise_vec,
    output raise_status_e      raise_status,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_vec,
    input  logic               eoi_valid,
    input  logic [IDX_W-1:0]   eoi_idx,
    input  logic               en_we,
    input  logic [IDX_W-1:0]   en_vec,
    input  logic               en_val,
    output logic [NUM_VEC-1:0] req_q,
    output logic [NUM_VEC-1:0] isr_q
);
    localparam int unsigned NUM_BYTES = NUM_VEC / 8;
    localparam logic [RAISE_W-1:0] LOW_LIM = RAISE_W'(LOW_RSVD);
    localparam logic [RAISE_W-1:0] TOP_LIM = RAISE_W'(NUM_VEC);

    logic [NUM_VEC-1:0] en_q;
    logic [IDX_W-1:0]   raise_idx;
    logic               raise_err, raise_hit, raise_on, raise_new, ack_hit;
    logic [NUM_VEC-1:0] set_m, clr_m, ack_m, eoi_m, en_sel;

    assign raise_idx = raise_vec[IDX_W-1:0];
    assign raise_err = raise_valid && ((raise_vec < LOW_LIM) || (raise_vec >= TOP_LIM));
    assign raise_hit = req_q[raise_idx];
    assign raise_on  = en_q[raise_idx];
    assign raise_new = raise_valid && !raise_err && !raise_hit && raise_on;
    assign ack_hit   = ack_valid && req_q[ack_vec];

    always_comb begin
        if (!raise_valid)   raise_status = RS_OK;
        else if (raise_err) raise_status = RS_ERROR;
        else if (raise_new) raise_status = RS_SERVICE;
        else                raise_status = RS_OK;
    end

    assign set_m  = raise_new ? (NUM_VEC'(1) << raise_idx) : '0;
    assign clr_m  = ack_hit   ? (NUM_VEC'(1) << ack_vec)   : '0;
    assign ack_m  = clr_m;
    assign eoi_m  = eoi_valid ? (NUM_VEC'(1) << eoi_idx)   : '0;
    assign en_sel = en_we     ? (NUM_VEC'(1) << en_vec)    : '0;

    // Storage kept as byte lanes: lane = vector >> 3, bit = vector[2:0].
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        logic [7:0] req_b, isr_b, en_b;
        always_ff @(posedge clk) begin
            if (rst) begin
                req_b <= '0;
                isr_b <= '0;
                en_b  <= '0;
            end else begin
                req_b <= (req_b | set_m[g*8 +: 8]) & ~clr_m[g*8 +: 8];
                isr_b <= (isr_b & ~eoi_m[g*8 +: 8]) | ack_m[g*8 +: 8];
                en_b  <= (en_b & ~en_sel[g*8 +: 8]) | (en_sel[g*8 +: 8] & {8{en_val}});
            end
        end
        assign req_q[g*8 +: 8] = req_b;
        assign isr_q[g*8 +: 8] = isr_b;
        assign en_q[g*8 +: 8]  = en_b;
    end

    // R1: reserved low vectors can never become requested
    p_low_clear_r1: assert property (@(posedge clk) disable iff (rst)
        req_q[LOW_RSVD-1:0] == '0);

    // R1: a refused raise leaves the request set untouched
    p_err_keeps_r1: assert property (@(posedge clk) disable iff (rst)
        (raise_valid && raise_status == RS_ERROR && !ack_valid) |=> req_q == $past(req_q));

    // R3: a SERVICE answer is followed by the request bit being set
    p_new_req_r3: assert property (@(posedge clk) disable iff (rst)
        (raise_valid && raise_status == RS_SERVICE && !ack_valid) |=> req_q[$past(raise_idx)]);

    // R4: raise of a disabled vector is dropped
    p_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (raise_valid && !en_q[raise_idx] && !ack_valid) |=> req_q == $past(req_q));

    // R5: enable write lands on the addressed bit
    p_en_write_r5: assert property (@(posedge clk) disable iff (rst)
        en_we |=> en_q[$past(en_vec)] == $past(en_val));

    // R6: acknowledge moves a request into service
    p_ack_move_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && req_q[ack_vec]) |=> (isr_q[$past(ack_vec)] && !req_q[$past(ack_vec)]));
endmodule

// File: rtl/irq_track.sv
module irq_track
    import irq_trk_pkg::*;
#(
    parameter int unsigned NUM_VEC  = 256,
    parameter int unsigned LOW_RSVD = 16,
    parameter int unsigned IDX_W    = $clog2(NUM_VEC),
    parameter int unsigned RAISE_W  = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               raise_valid,
    input  logic [RAISE_W-1:0] raise_vec,
    output logic [1:0]         raise_status,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_vec,
    input  logic               eoi,
    input  logic               en_we,
    input  logic [IDX_W-1:0]   en_vec,
    input  logic               en_val,
    output logic               pend,
    output logic [IDX_W-1:0]   pend_vec
);
    logic [NUM_VEC-1:0] req_q, isr_q;
    logic               req_any, isr_any;
    logic [IDX_W-1:0]   req_hi, isr_hi;
    raise_status_e      status_w;

    irq_vec_bank #(
        .NUM_VEC(NUM_VEC), .LOW_RSVD(LOW_RSVD), .IDX_W(IDX_W), .RAISE_W(RAISE_W)
    ) u_bank (
        .clk(clk), .rst(rst),
        .raise_valid(raise_valid), .raise_vec(raise_vec), .raise_status(status_w),
        .ack_valid(ack_valid), .ack_vec(ack_vec),
        .eoi_valid(eoi && isr_any), .eoi_idx(isr_hi),
        .en_we(en_we), .en_vec(en_vec), .en_val(en_val),
        .req_q(req_q), .isr_q(isr_q)
    );

    irq_hi_find #(.WIDTH(NUM_VEC), .IDX_W(IDX_W)) u_req_find (
        .bits(req_q), .found(req_any), .idx(req_hi)
    );

    irq_hi_find #(.WIDTH(NUM_VEC), .IDX_W(IDX_W)) u_isr_find (
        .bits(isr_q), .found(isr_any), .idx(isr_hi)
    );

    assign raise_status = status_w;
    assign pend         = req_any && (!isr_any || (req_hi > isr_hi));
    assign pend_vec     = pend ? req_hi : '0;

    // R7: EOI retires the vector that was highest in service
    p_eoi_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (eoi && isr_any && !ack_valid) |=> !isr_q[$past(isr_hi)]);

    // R8: a pending vector is always a real request
    p_pend_real_r8: assert property (@(posedge clk) disable iff (rst)
        pend |-> req_q[pend_vec]);

    // R8: pending vector outranks everything in service
    p_pend_rank_r8: assert property (@(posedge clk) disable iff (rst)
        pend |-> (isr_q >> pend_vec) == '0);
endmodule

// File: tb/sim_irq_track.sv
module sim_irq_track;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raise_valid = 1'b0;
    logic [8:0] raise_vec = '0;
    logic [1:0] raise_status;
    logic       ack_valid = 1'b0;
    logic [7:0] ack_vec = '0;
    logic       eoi = 1'b0;
    logic       en_we = 1'b0;
    logic [7:0] en_vec = '0;
    logic       en_val = 1'b0;
    logic       pend;
    logic [7:0] pend_vec;

    int tests = 0;
    int failed = 0;
    bit done = 0;

    bit [255:0] m_req, m_isr, m_en;

    // expectation queues (scoreboard)
    bit        q_chk[$];
    bit [1:0]  q_stat[$];
    bit        q_pend[$];
    bit [7:0]  q_pvec[$];
    string     q_tag[$];

    always #10 clk = ~clk;

    irq_track u0 (
        .clk(clk), .rst(rst),
        .raise_valid(raise_valid), .raise_vec(raise_vec), .raise_status(raise_status),
        .ack_valid(ack_valid), .ack_vec(ack_vec), .eoi(eoi),
        .en_we(en_we), .en_vec(en_vec), .en_val(en_val),
        .pend(pend), .pend_vec(pend_vec)
    );

    function automatic int top_bit(bit [255:0] v);
        int h = -1;
        for (int i = 0; i < 256; i++) if (v[i]) h = i;
        return h;
    endfunction

    task automatic drive(bit rv, int rvec, bit av, int avec, bit e,
                         bit ew, int evec, bit ev, bit r, string tag);
        int  rh, ih;
        bit  err, ep, sv;
        bit [1:0] st;
        bit [255:0] setm, clrm, eoim;
        @(negedge clk);
        rst = r; raise_valid = rv; raise_vec = 9'(rvec);
        ack_valid = av; ack_vec = 8'(avec); eoi = e;
        en_we = ew; en_vec = 8'(evec); en_val = ev;
        rh = top_bit(m_req);
        ih = top_bit(m_isr);
        ep = (rh >= 0) && (ih < 0 || rh > ih);
        err = rv && (rvec < 16 || rvec > 255);
        sv = rv && !err && !m_req[rvec] && m_en[rvec];
        st = err ? 2'b10 : (sv ? 2'b01 : 2'b00);
        q_chk.push_back(rv); q_stat.push_back(st);
        q_pend.push_back(ep); q_pvec.push_back(ep ? 8'(rh) : 8'd0);
        q_tag.push_back(tag);
        if (r) begin
            m_req = '0; m_isr = '0; m_en = '0;
        end else begin
            setm = '0; clrm = '0; eoim = '0;
            if (sv) setm[rvec] = 1'b1;
            if (av && m_req[avec]) clrm[avec] = 1'b1;
            if (e && ih >= 0) eoim[ih] = 1'b1;
            m_req = (m_req | setm) & ~clrm;
            m_isr = (m_isr & ~eoim) | clrm;
            if (ew) m_en[evec] = ev;
        end
    endtask

    task automatic idle(string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic raise(int v, string tag);
        drive(1, v, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic enable(int v, bit val, string tag);
        drive(0, 0, 0, 0, 0, 1, v, val, 0, tag);
    endtask

    task automatic ack(int v, string tag);
        drive(0, 0, 1, v, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compares each expected item away from the active edge
    always @(negedge clk) begin
        #5;
        if (q_tag.size() > 0) begin
            bit c; bit [1:0] s; bit p; bit [7:0] pv; string t;
            c = q_chk.pop_front(); s = q_stat.pop_front();
            p = q_pend.pop_front(); pv = q_pvec.pop_front(); t = q_tag.pop_front();
            if (c) begin
                tests++;
                if (raise_status !== s) begin
                    failed++;
                    $display("FAIL %s status: actual %b expected %b", t, raise_status, s);
                end
            end
            tests++;
            if (pend !== p) begin
                failed++;
                $display("FAIL %s pend: actual %b expected %b", t, pend, p);
            end
            tests++;
            if (pend_vec !== pv) begin
                failed++;
                $display("FAIL %s pend_vec: actual %0d expected %0d", t, pend_vec, pv);
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            failed++;
            $display("[TB] watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        bit [31:0] lfsr;
        m_req = '0; m_isr = '0; m_en = '0;
        // R9: reset state
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
        idle("R9");
        // R1: out-of-range vectors
        raise(5, "R1");
        raise(15, "R1");
        raise(300, "R1");
        raise(511, "R1");
        idle("R1");
        // R4: disabled vector dropped
        raise(40, "R4");
        idle("R4");
        // R5: enable writes; same-cycle raise sees old enable
        enable(40, 1, "R5");
        enable(100, 1, "R5");
        enable(200, 1, "R5");
        enable(16, 1, "R5");
        enable(255, 1, "R5");
        drive(1, 60, 0, 0, 0, 1, 60, 1, 0, "R5");
        idle("R5");
        // R3 / R2: new request, then coalesced
        raise(40, "R3");
        raise(40, "R2");
        idle("R8");
        raise(100, "R3");
        idle("R8");
        // R6: acknowledge moves 100 into service; 40 held back (R8)
        ack(100, "R6");
        idle("R8");
        ack(50, "R6");
        idle("R6");
        raise(200, "R3");
        idle("R8");
        ack(200, "R6");
        idle("R8");
        // R7: EOI retires 200, then 100
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
        idle("R7");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
        idle("R7");
        ack(40, "R6");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
        idle("R7");
        // boundaries 16 and 255
        raise(16, "R3");
        raise(255, "R3");
        idle("R8");
        // R10: raise and ack of same requested vector in one cycle
        drive(1, 255, 1, 255, 0, 0, 0, 0, 0, "R10");
        idle("R10");
        // R10: raise a new vector while acking another and EOI together
        enable(100, 1, "R5");
        drive(1, 100, 1, 16, 1, 0, 0, 0, 0, "R10");
        idle("R10");
        // disable then raise: dropped (R4)
        enable(200, 0, "R4");
        raise(200, "R4");
        idle("R4");
        // R9: reset mid-run clears enables too
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
        idle("R9");
        raise(40, "R9");
        idle("R9");
        // enable every legal vector, then a mixed stream
        for (int v = 16; v < 256; v++) enable(v, 1, "R5");
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(lfsr[0], int'(lfsr[12:4]) & ((lfsr[1]) ? 255 : 511),
                  lfsr[2] && lfsr[3], int'(lfsr[20:13]),
                  lfsr[21] && lfsr[22] && lfsr[23],
                  lfsr[24] && lfsr[25] && lfsr[26], int'(lfsr[31:24]), lfsr[27],
                  0, "R10");
        end
        idle("R8");
        idle("R8");
        idle("R8");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule